// File: doc/BRIEF.md
# SWD Link Wake-up and Identify Sequencer

This block takes a Serial Wire Debug target whose debug port is in an unknown state, switches it into SWD operation, and proves the link by reading the debug port identification register. It drives the serial clock and controls a bidirectional data line through a separate data-out and output-enable pair, with the returning line level on `swdio_in`.

A one-cycle `start` pulse starts a fixed bit sequence. First comes a line reset of 66 high bits. Next the 16-bit mode switch word 0xE79E goes out, least significant bit first. A second line reset of 50 high bits and 16 low idle bits follow. The host then sends the identification read request 0xA5 and releases the line for one turnaround bit. It samples a 3-bit acknowledge and, if that reads OK, samples 32 data bits and an even parity bit. The sequence ends with a final turnaround bit. A one-cycle `done` pulse comes with exactly one of `link_ok` or `link_fail`. The captured identification value is published only on success.

The serial clock runs from a fixed divider: each clock half lasts `DIV_HALF` system cycles. The host changes the data line only while the serial clock is low, at its falling edge. It samples target data on the rising edge.

Top module: `swd_link_wakeup`

## Requirements
- R1: After reset, `swclk`, `swdio_oe`, `swdio_out`, `done`, `link_ok` and `link_fail` are 0 and `idcode` is 0.
- R2: While a sequence runs, each high half of `swclk` lasts `DIV_HALF` system cycles and consecutive rising edges are 2*`DIV_HALF` cycles apart. Outside a sequence `swclk` stays low.
- R3: Serial bits 0 to 65 (counted by rising `swclk` edges from 0) are driven high with `swdio_oe` = 1.
- R4: Bits 66 to 81 carry 0xE79E with bit 66 = word bit 0, driven.
- R5: Bits 82 to 131 are driven high and bits 132 to 147 are driven low.
- R6: Bits 148 to 155 carry the request 0xA5 with bit 148 = request bit 0, driven.
- R7: `swdio_oe` is 0 for bit 156 (turnaround), for every acknowledge, data and parity bit, and for the final turnaround bit.
- R8: `swdio_out` and `swdio_oe` change only in cycles where `swclk` is low after the edge.
- R9: The acknowledge is bits 157 to 159, first received bit = acknowledge bit 0. Only the value 3'b001 is accepted. Any other value skips the data phase: one turnaround bit follows (161 rising edges in total) and the run ends in failure.
- R10: On an OK acknowledge, bits 160 to 191 are the data (first bit = bit 0) and bit 192 is parity. The run succeeds only if parity equals the XOR of the 32 data bits. A mismatch fails. The sequence has 194 rising edges.
- R11: On success, `done` and `link_ok` are high for exactly one cycle and `idcode` takes the received data.
- R12: On failure, `done` and `link_fail` are high for exactly one cycle together and `idcode` keeps its previous value.
- R13: A `start` pulse during a running sequence has no effect on the bit count or outcome.
- R14: After `done`, the host drives the line low (`swdio_oe` = 1, `swdio_out` = 0) with `swclk` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins the wake-up sequence |
| swdio_in | input | 1 | Sampled level of the bidirectional data line |
| swclk | output | 1 | Serial clock to the target |
| swdio_out | output | 1 | Level driven onto the data line when enabled |
| swdio_oe | output | 1 | Data line output enable, 1 = host drives |
| done | output | 1 | One-cycle end-of-sequence pulse |
| link_ok | output | 1 | Pulses with `done` when acknowledge and parity are good |
| link_fail | output | 1 | Pulses with `done` on bad acknowledge or parity |
| idcode | output | 32 | Last successfully read identification value |

## Verification
Two functions can land in the same cycle. One is the end of a sequence, where the bus is handed back and the verdict is published. The other is a new `start` request, or an outcome that touches the held identification value. The bench fires a second `start` part-way through every run and checks that the rising-edge count stays at 194 or 161. Failing runs on bad acknowledge values and on a flipped parity bit are placed right after a successful one. There, `done`, `link_fail` and an unchanged `idcode` must all show in the same sampled cycle.

// File: rtl/swd_wake_pkg.sv
package swd_wake_pkg;

  localparam int ID_W   = 32;
  localparam int ACK_W  = 3;
  localparam int IDX_W  = 7;

  localparam logic [15:0]      SWITCH_WORD = 16'hE79E;
  localparam logic [7:0]       ID_REQUEST  = 8'hA5;
  localparam logic [ACK_W-1:0] ACK_GOOD    = 3'b001;

  localparam logic [IDX_W-1:0] LEN_RESET_A = 7'd66;
  localparam logic [IDX_W-1:0] LEN_SWITCH  = 7'd16;
  localparam logic [IDX_W-1:0] LEN_RESET_B = 7'd50;
  localparam logic [IDX_W-1:0] LEN_IDLE    = 7'd16;
  localparam logic [IDX_W-1:0] LEN_REQ     = 7'd8;
  localparam logic [IDX_W-1:0] LEN_ONE     = 7'd1;
  localparam logic [IDX_W-1:0] LEN_ACK     = 7'(ACK_W);
  localparam logic [IDX_W-1:0] LEN_DATA    = 7'(ID_W);

  typedef enum logic [3:0] {
    PH_RESET_A,
    PH_SWITCH,
    PH_RESET_B,
    PH_IDLE,
    PH_REQ,
    PH_TURN_IN,
    PH_ACK,
    PH_DATA,
    PH_PARITY,
    PH_TURN_OUT
  } wake_phase_e;

  function automatic logic [IDX_W-1:0] phase_len(input wake_phase_e ph);
    case (ph)
      PH_RESET_A: phase_len = LEN_RESET_A;
      PH_SWITCH:  phase_len = LEN_SWITCH;
      PH_RESET_B: phase_len = LEN_RESET_B;
      PH_IDLE:    phase_len = LEN_IDLE;
      PH_REQ:     phase_len = LEN_REQ;
      PH_ACK:     phase_len = LEN_ACK;
      PH_DATA:    phase_len = LEN_DATA;
      default:    phase_len = LEN_ONE;
    endcase
  endfunction

endpackage

// File: rtl/swd_half_timer.sv
module swd_half_timer #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);

  generate
    if (DIV_HALF <= 1) begin : g_every_cycle
      always_ff @(posedge clk) begin
        if (rst) tick <= 1'b0;
        else     tick <= en;
      end
    end else begin : g_counted
      localparam int CNT_W = $clog2(DIV_HALF);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || !en) begin
          cnt  <= '0;
          tick <= 1'b0;
        end else if (cnt == CNT_LAST) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt  <= cnt + 1'b1;
          tick <= 1'b0;
        end
      end
    end
  endgenerate

  // R2: a half-period tick only follows a cycle in which the timer ran
  a_r2_tick_needs_en: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(en));

endmodule

// File: rtl/swd_host_drive.sv
module swd_host_drive
  import swd_wake_pkg::*;
(
  input  wake_phase_e      phase,
  input  logic [IDX_W-1:0] idx,
  output logic             drv,
  output logic             oe
);

  logic [15:0] sw_shift;
  logic [7:0]  rq_shift;

  always_comb begin
    sw_shift = SWITCH_WORD >> idx;
    rq_shift = ID_REQUEST >> idx;
    case (phase)
      PH_RESET_A, PH_RESET_B: begin drv = 1'b1;        oe = 1'b1; end
      PH_SWITCH:              begin drv = sw_shift[0]; oe = 1'b1; end
      PH_IDLE:                begin drv = 1'b0;        oe = 1'b1; end
      PH_REQ:                 begin drv = rq_shift[0]; oe = 1'b1; end
      default:                begin drv = 1'b0;        oe = 1'b0; end
    endcase
  end

endmodule

// File: rtl/swd_rx_capture.sv
module swd_rx_capture
  import swd_wake_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample,
  input  wake_phase_e      phase,
  input  logic             din,
  output logic [ACK_W-1:0] ack,
  output logic [ID_W-1:0]  data,
  output logic             parity_ok
);

  logic par_bit;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ack     <= '0;
      data    <= '0;
      par_bit <= 1'b0;
    end else if (sample) begin
      case (phase)
        PH_ACK:    ack     <= {din, ack[ACK_W-1:1]};
        PH_DATA:   data    <= {din, data[ID_W-1:1]};
        PH_PARITY: par_bit <= din;
        default:   ;
      endcase
    end
  end

  assign parity_ok = (par_bit == ^data);

  // R9: acknowledge register moves only on a sample taken in the acknowledge phase
  a_r9_ack_only_in_ack: assert property (@(posedge clk) disable iff (rst)
    (!clear && !(sample && phase == PH_ACK)) |=> $stable(ack));

endmodule

// File: rtl/swd_link_wakeup.sv
module swd_link_wakeup
  import swd_wake_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            swdio_in,
  output logic            swclk,
  output logic            swdio_out,
  output logic            swdio_oe,
  output logic            done,
  output logic            link_ok,
  output logic            link_fail,
  output logic [ID_W-1:0] idcode
);

  logic             busy;
  wake_phase_e      phase, nxt_phase, drv_phase;
  logic [IDX_W-1:0] idx, nxt_idx, drv_idx;
  logic             tick, finish, h_drv, h_oe, sample, cap_clear;
  logic [ACK_W-1:0] rx_ack;
  logic [ID_W-1:0]  rx_data;
  logic             rx_par_ok;

  swd_half_timer #(.DIV_HALF(DIV_HALF)) u_timer (
    .clk (clk),
    .rst (rst),
    .en  (busy),
    .tick(tick)
  );

  // next serial bit position
  always_comb begin
    nxt_phase = phase;
    nxt_idx   = idx + 1'b1;
    finish    = 1'b0;
    if (idx == phase_len(phase) - 1'b1) begin
      nxt_idx = '0;
      case (phase)
        PH_RESET_A:  nxt_phase = PH_SWITCH;
        PH_SWITCH:   nxt_phase = PH_RESET_B;
        PH_RESET_B:  nxt_phase = PH_IDLE;
        PH_IDLE:     nxt_phase = PH_REQ;
        PH_REQ:      nxt_phase = PH_TURN_IN;
        PH_TURN_IN:  nxt_phase = PH_ACK;
        PH_ACK:      nxt_phase = (rx_ack == ACK_GOOD) ? PH_DATA : PH_TURN_OUT;
        PH_DATA:     nxt_phase = PH_PARITY;
        PH_PARITY:   nxt_phase = PH_TURN_OUT;
        default:     finish    = 1'b1;
      endcase
    end
  end

  assign drv_phase = busy ? nxt_phase : PH_RESET_A;
  assign drv_idx   = busy ? nxt_idx   : '0;

  swd_host_drive u_drive (
    .phase(drv_phase),
    .idx  (drv_idx),
    .drv  (h_drv),
    .oe   (h_oe)
  );

  assign cap_clear = !busy && start;
  assign sample    = busy && tick && !swclk;

  swd_rx_capture u_capture (
    .clk      (clk),
    .rst      (rst),
    .clear    (cap_clear),
    .sample   (sample),
    .phase    (phase),
    .din      (swdio_in),
    .ack      (rx_ack),
    .data     (rx_data),
    .parity_ok(rx_par_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      phase     <= PH_RESET_A;
      idx       <= '0;
      swclk     <= 1'b0;
      swdio_out <= 1'b0;
      swdio_oe  <= 1'b0;
      done      <= 1'b0;
      link_ok   <= 1'b0;
      link_fail <= 1'b0;
      idcode    <= '0;
    end else begin
      done      <= 1'b0;
      link_ok   <= 1'b0;
      link_fail <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          phase     <= PH_RESET_A;
          idx       <= '0;
          swdio_out <= h_drv;
          swdio_oe  <= h_oe;
        end
      end else if (tick) begin
        if (!swclk) begin
          swclk <= 1'b1;
        end else begin
          swclk <= 1'b0;
          if (finish) begin
            busy      <= 1'b0;
            swdio_out <= 1'b0;
            swdio_oe  <= 1'b1;
            done      <= 1'b1;
            if (rx_ack == ACK_GOOD && rx_par_ok) begin
              link_ok <= 1'b1;
              idcode  <= rx_data;
            end else begin
              link_fail <= 1'b1;
            end
          end else begin
            phase     <= nxt_phase;
            idx       <= nxt_idx;
            swdio_out <= h_drv;
            swdio_oe  <= h_oe;
          end
        end
      end
    end
  end

  // R2: serial clock is parked low whenever no sequence runs
  a_r2_clk_parked: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !swclk);

  // R8: data line changes only while the serial clock is low
  a_r8_change_on_low: assert property (@(posedge clk) disable iff (rst)
    (!$stable(swdio_out) || !$stable(swdio_oe)) |-> !swclk);

  // R7: line released during every target-driven bit
  a_r7_released: assert property (@(posedge clk) disable iff (rst)
    (busy && (phase == PH_TURN_IN || phase == PH_ACK || phase == PH_DATA ||
              phase == PH_PARITY || phase == PH_TURN_OUT)) |-> !swdio_oe);

  // R11 / R12: each completion carries exactly one verdict
  a_r11_one_verdict: assert property (@(posedge clk) disable iff (rst)
    done |-> ($countones({link_ok, link_fail}) == 1));

  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12: a failed run leaves the identification value untouched
  a_r12_hold_id: assert property (@(posedge clk) disable iff (rst)
    link_fail |-> $stable(idcode));

  // R14: bus handed back to the host, driven low, once a run ends
  a_r14_handback: assert property (@(posedge clk) disable iff (rst)
    done |-> (swdio_oe && !swdio_out && !swclk));

endmodule

// File: tb/tb_swd_link_wakeup.sv
`timescale 1ns/1ps
module tb_swd_link_wakeup;

  localparam int  DIV_HALF = 2;
  localparam time TCLK     = 4ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        swdio_in = 1'b1;
  logic        swclk, swdio_out, swdio_oe, done, link_ok, link_fail;
  logic [31:0] idcode;

  int total = 0;
  int bad   = 0;

  // target model state
  logic [2:0]  t_ack = 3'b001;
  logic [31:0] t_id  = '0;
  logic        t_par = 1'b0;
  int          rise_cnt = 0;
  bit          active = 1'b0;
  time         last_rise = 0;

  swd_link_wakeup #(.DIV_HALF(DIV_HALF)) dut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .swdio_in (swdio_in),
    .swclk    (swclk),
    .swdio_out(swdio_out),
    .swdio_oe (swdio_oe),
    .done     (done),
    .link_ok  (link_ok),
    .link_fail(link_fail),
    .idcode   (idcode)
  );

  always #(TCLK/2) clk = ~clk;

  task automatic check(input bit cond, input string req, input longint act, input longint exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic tgt_bit(input int i);
    if (i >= 157 && i <= 159) return t_ack[i-157];
    if (i >= 160 && i <= 191) return t_id[i-160];
    if (i == 192)             return t_par;
    return 1'b1;
  endfunction

  // target side: watch host bits on each rising serial clock, present next target bit
  initial begin
    forever begin
      @(posedge swclk);
      #1;
      if (active) begin
        int k;
        logic [15:0] sw;
        logic [7:0]  rq;
        k  = rise_cnt;
        sw = 16'hE79E;
        rq = 8'hA5;
        if (k > 0)
          check(($time - last_rise) == 2*DIV_HALF*TCLK, "R2 period",
                longint'($time - last_rise), longint'(2*DIV_HALF*TCLK));
        last_rise = $time;
        if (k <= 65)
          check(swdio_oe && swdio_out, "R3", {swdio_oe, swdio_out}, 2'b11);
        else if (k <= 81)
          check(swdio_oe && swdio_out == sw[k-66], "R4", {swdio_oe, swdio_out}, {1'b1, sw[k-66]});
        else if (k <= 131)
          check(swdio_oe && swdio_out, "R5 high", {swdio_oe, swdio_out}, 2'b11);
        else if (k <= 147)
          check(swdio_oe && !swdio_out, "R5 low", {swdio_oe, swdio_out}, 2'b10);
        else if (k <= 155)
          check(swdio_oe && swdio_out == rq[k-148], "R6", {swdio_oe, swdio_out}, {1'b1, rq[k-148]});
        else
          check(!swdio_oe, "R7", swdio_oe, 0);
        rise_cnt = k + 1;
        swdio_in = tgt_bit(k + 1);
      end
    end
  end

  // high half of the serial clock
  initial begin
    forever begin
      @(negedge swclk);
      #1;
      if (active)
        check(($time - 1ns - (last_rise - 1ns)) == DIV_HALF*TCLK, "R2 high",
              longint'($time - last_rise), longint'(DIV_HALF*TCLK));
    end
  end

  logic [31:0] exp_id = '0;

  task automatic run_case(input logic [2:0] ack, input logic [31:0] id, input bit flip);
    bit good;
    bit seen;
    int exp_rises;
    t_ack = ack;
    t_id  = id;
    t_par = (^id) ^ flip;
    good  = (ack == 3'b001) && !flip;
    exp_rises = (ack == 3'b001) ? 194 : 161;
    rise_cnt = 0;
    active   = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    seen = 1'b0;
    for (int c = 0; c < 4000 && !seen; c++) begin
      @(negedge clk);
      if (c == 150) start = 1'b1;   // R13: request while running
      if (c == 151) start = 1'b0;
      if (done) seen = 1'b1;
    end
    start = 1'b0;
    check(seen, "R11 done seen", seen, 1);
    if (seen) begin
      if (good) exp_id = id;
      check(rise_cnt == exp_rises, (ack == 3'b001) ? "R10 R13 bit count" : "R9 R13 bit count",
            rise_cnt, exp_rises);
      check(link_ok == good, "R11 ok", link_ok, good);
      check(link_fail == !good, good ? "R11 fail" : (flip ? "R10 fail" : "R9 fail"), link_fail, !good);
      check(idcode == exp_id, good ? "R11 idcode" : "R12 idcode held", idcode, exp_id);
      check(swdio_oe && !swdio_out && !swclk, "R14", {swclk, swdio_oe, swdio_out}, 3'b010);
      @(negedge clk);
      check(!done && !link_ok && !link_fail, "R12 single pulse", {done, link_ok, link_fail}, 0);
    end
    active = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  bit finished = 1'b0;

  initial begin
    #(200000 * TCLK);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!swclk && !swdio_oe && !swdio_out && !done && !link_ok && !link_fail,
          "R1 outputs", {swclk, swdio_oe, swdio_out, done, link_ok, link_fail}, 0);
    check(idcode == 0, "R1 idcode", idcode, 0);
    repeat (10) @(negedge clk);
    check(!swclk, "R2 parked", swclk, 0);

    run_case(3'b001, 32'h0BC11477, 1'b0);
    for (int a = 0; a < 8; a++)
      if (a != 1) run_case(3'(a), 32'hDEADBEEF, 1'b0);
    run_case(3'b001, 32'h00000000, 1'b0);
    run_case(3'b001, 32'hFFFFFFFF, 1'b0);
    run_case(3'b001, 32'h00000001, 1'b1);
    run_case(3'b001, 32'h80000000, 1'b0);
    run_case(3'b001, 32'h2BA01477, 1'b1);
    run_case(3'b001, 32'hA5A5A5A5, 1'b0);
    run_case(3'b100, 32'h12345678, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule